// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits beside one processor and decides which interrupt, if any, that processor should see. It keeps the processor's current priority threshold and an inter-processor interrupt (IPI) request priority. It also watches a single candidate offered by the external source side. A candidate is presented only when its priority number is strictly below the current threshold. A lower number is more favoured. A threshold of 0 shuts everything out, and a threshold of 0xFF lets every real priority through.

Software reaches the block through a 16-byte window on a 32-bit register bus. The data is big-endian: byte 0 is bits 31:24 and is selected by byte enable bit 3. One word gives a side-effect-free view of the presented interrupt. A second word holds the same data, but reading it takes the interrupt and raises the threshold to that interrupt's priority. Writing that second word either sets the threshold alone (a byte write) or completes an interrupt (a full-word write). The full-word write restores the threshold and reports the finished source number to the source side. The last word posts or withdraws the IPI, which is presented as source number 2.

Read data is combinational during a read cycle. All state changes take place at the clock edge that ends the access.

Top module: `intr_presenter`

## Requirements
- R1: After reset the threshold is 0, the IPI request is 0xFF (none), irq_o is low, a peek read returns 0x00000000 and an IPI-word read returns 0xFF000000.
- R2: irq_o is high exactly when the IPI priority, or the priority of a valid external source, is strictly less than the threshold.
- R3: A read of byte offset 0x0 returns {threshold[31:24], presented source[23:0]} and changes no state. The source field is 0 when nothing is presented.
- R4: A read of offset 0x4 returns the same word as R3. If something is presented, that read sets the threshold to its priority. An external winner raises src_accept_o for that cycle, and an IPI winner sets the IPI request back to 0xFF. With nothing presented, the read returns source 0 and changes nothing.
- R5: A write to offset 0xC with byte enable bit 3 set loads bits 31:24 as the IPI priority, and 0xFF withdraws the IPI. A read of 0xC returns {IPI priority, 24'h0}, and a presented IPI carries source number 2.
- R6: When both candidates qualify, the lower priority number wins, and on equal numbers the IPI wins.
- R7: A write to offset 0x4 with byte enables 4'b1000 sets only the threshold from bits 31:24 and gives no completion pulse.
- R8: A write to offset 0x4 with all byte enables set is a completion. eoi_valid_o is high in that cycle with eoi_num_o equal to bits 23:0, and the threshold takes bits 31:24.
- R9: Writes to offsets 0x0 and 0x8, and writes to 0x4 with any other byte-enable pattern, change nothing. A read of 0x8 returns 0.
- R10: A threshold of 0 keeps irq_o low whatever is offered, and an IPI priority of 0xFF is never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address in the window |
| bus_be_i | input | BE_W | Byte enables, bit 3 = bits 31:24 |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid during a read cycle |
| src_valid_i | input | 1 | External candidate offered |
| src_num_i | input | SRC_W | External candidate source number |
| src_prio_i | input | PRIO_W | External candidate priority |
| src_accept_o | output | 1 | External candidate taken this cycle |
| eoi_valid_o | output | 1 | Completion written this cycle |
| eoi_num_o | output | SRC_W | Completed source number |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The properties assume one bus access per cycle. They also assume that the source side holds its candidate steady within a cycle and only changes it between accesses. The ordering checks further assume that a taking read never coincides with an IPI write, which the single-access bus already guarantees. The stimulus changes the external candidate only at falling edges outside bus cycles. It issues one access at a time and releases the bus after each rising edge, so every property sees a legal input sequence.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

  typedef enum logic [1:0] {
    SLOT_PEEK = 2'd0,
    SLOT_TAKE = 2'd1,
    SLOT_RSVD = 2'd2,
    SLOT_IPI  = 2'd3
  } ipres_slot_t;

  typedef struct packed {
    logic peek_rd;
    logic take_rd;
    logic rsvd_rd;
    logic ipi_rd;
    logic cppr_wr;
    logic eoi_wr;
    logic ipi_wr;
  } ipres_strobe_t;

endpackage

// File: rtl/ipres_decode.sv
module ipres_decode
  import ipres_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BE_W   = 4
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output ipres_strobe_t     stb
);

  logic        hit;
  ipres_slot_t slot;
  logic        be_full;
  logic        be_top_only;
  logic        be_top;

  generate
    if (ADDR_W > 4) begin : g_wide
      assign hit = req && (addr[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign hit = req;
    end
  endgenerate

  assign slot        = ipres_slot_t'(addr[3:2]);
  assign be_full     = &be;
  assign be_top_only = (be == {1'b1, {(BE_W-1){1'b0}}});
  assign be_top      = be[BE_W-1];

  always_comb begin
    stb = '0;
    if (hit && !we) begin
      unique case (slot)
        SLOT_PEEK: stb.peek_rd = 1'b1;
        SLOT_TAKE: stb.take_rd = 1'b1;
        SLOT_RSVD: stb.rsvd_rd = 1'b1;
        SLOT_IPI:  stb.ipi_rd  = 1'b1;
        default:   ;
      endcase
    end else if (hit && we) begin
      unique case (slot)
        SLOT_TAKE: begin
          stb.eoi_wr  = be_full;
          stb.cppr_wr = be_top_only;
        end
        SLOT_IPI:  stb.ipi_wr = be_top;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/ipres_select.sv
module ipres_select #(
  parameter int PRIO_W       = 8,
  parameter int SRC_W        = 24,
  parameter int IPI_SRC      = 2,
  parameter bit IPI_WINS_TIE = 1'b1
) (
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic              src_valid,
  input  logic [SRC_W-1:0]  src_num,
  input  logic [PRIO_W-1:0] src_prio,
  output logic              win_valid,
  output logic              win_ipi,
  output logic [SRC_W-1:0]  win_num,
  output logic [PRIO_W-1:0] win_prio
);

  function automatic logic admits(input logic [PRIO_W-1:0] p,
                                  input logic [PRIO_W-1:0] thr);
    return p < thr;
  endfunction

  logic ext_ok;
  logic ipi_ok;
  logic ipi_beats;

  assign ext_ok = src_valid && admits(src_prio, cppr);
  assign ipi_ok = admits(ipi_prio, cppr);

  generate
    if (IPI_WINS_TIE) begin : g_tie_ipi
      assign ipi_beats = ipi_prio <= src_prio;
    end else begin : g_tie_ext
      assign ipi_beats = ipi_prio < src_prio;
    end
  endgenerate

  always_comb begin
    win_valid = ext_ok || ipi_ok;
    win_ipi   = ipi_ok && (!ext_ok || ipi_beats);
    if (win_ipi) begin
      win_num  = SRC_W'(IPI_SRC);
      win_prio = ipi_prio;
    end else if (ext_ok) begin
      win_num  = src_num;
      win_prio = src_prio;
    end else begin
      win_num  = '0;
      win_prio = '1;
    end
  end

endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import ipres_pkg::*;
#(
  parameter int  PRIO_W       = 8,
  parameter int  SRC_W        = 24,
  parameter int  ADDR_W       = 4,
  parameter int  IPI_SRC      = 2,
  parameter bit  IPI_WINS_TIE = 1'b1,
  localparam int DATA_W       = PRIO_W + SRC_W,
  localparam int BE_W         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              src_valid_i,
  input  logic [SRC_W-1:0]  src_num_i,
  input  logic [PRIO_W-1:0] src_prio_i,
  output logic              src_accept_o,
  output logic              eoi_valid_o,
  output logic [SRC_W-1:0]  eoi_num_o,
  output logic              irq_o
);

  function automatic logic [DATA_W-1:0] pack_word(input logic [PRIO_W-1:0] p,
                                                  input logic [SRC_W-1:0] n);
    return {p, n};
  endfunction

  function automatic logic [PRIO_W-1:0] top_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: PRIO_W];
  endfunction

  ipres_strobe_t     stb;
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [PRIO_W-1:0] ipi_q, ipi_d;
  logic              win_valid;
  logic              win_ipi;
  logic [SRC_W-1:0]  win_num;
  logic [PRIO_W-1:0] win_prio;
  logic              take_hit;

  ipres_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .req  (bus_req_i),
    .we   (bus_we_i),
    .addr (bus_addr_i),
    .be   (bus_be_i),
    .stb  (stb)
  );

  ipres_select #(
    .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC), .IPI_WINS_TIE(IPI_WINS_TIE)
  ) u_select (
    .cppr      (cppr_q),
    .ipi_prio  (ipi_q),
    .src_valid (src_valid_i),
    .src_num   (src_num_i),
    .src_prio  (src_prio_i),
    .win_valid (win_valid),
    .win_ipi   (win_ipi),
    .win_num   (win_num),
    .win_prio  (win_prio)
  );

  assign take_hit = stb.take_rd && win_valid;

  always_comb begin
    cppr_d = cppr_q;
    if (take_hit) begin
      cppr_d = win_prio;
    end else if (stb.cppr_wr || stb.eoi_wr) begin
      cppr_d = top_field(bus_wdata_i);
    end
  end

  always_comb begin
    ipi_d = ipi_q;
    if (stb.ipi_wr) begin
      ipi_d = top_field(bus_wdata_i);
    end else if (take_hit && win_ipi) begin
      ipi_d = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0;
      ipi_q  <= '1;
    end else begin
      cppr_q <= cppr_d;
      ipi_q  <= ipi_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (stb.peek_rd || stb.take_rd) begin
      bus_rdata_o = pack_word(cppr_q, win_num);
    end else if (stb.ipi_rd) begin
      bus_rdata_o = pack_word(ipi_q, '0);
    end
  end

  assign src_accept_o = take_hit && !win_ipi;
  assign eoi_valid_o  = stb.eoi_wr;
  assign eoi_num_o    = bus_wdata_i[SRC_W-1:0];
  assign irq_o        = win_valid;

endmodule

// File: rtl/ipres_chk.sv
module ipres_chk #(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [PRIO_W-1:0] ipi_q,
  input logic              win_valid,
  input logic              win_ipi,
  input logic [PRIO_W-1:0] win_prio,
  input logic              take_rd,
  input logic              peek_rd,
  input logic              eoi_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o,
  input logic              src_accept_o,
  input logic              src_valid_i,
  input logic [PRIO_W-1:0] src_prio_i
);

  // R4
  take_raises_cppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && win_valid |=> cppr_q == $past(win_prio));

  // R4
  take_clears_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && win_valid && win_ipi |=> ipi_q == '1);

  // R3
  peek_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peek_rd |=> $stable(cppr_q) && $stable(ipi_q));

  // R2
  irq_below_cppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> win_prio < cppr_q);

  // R6
  ext_only_when_better_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_accept_o |-> src_valid_i && (src_prio_i < cppr_q) && !(ipi_q <= src_prio_i));

  // R8
  eoi_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> cppr_q == $past(wdata[DATA_W-1 -: PRIO_W]));

  // R10
  zero_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cppr_q == '0 |-> !irq_o);

endmodule

bind intr_presenter ipres_chk #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cppr_q       (cppr_q),
  .ipi_q        (ipi_q),
  .win_valid    (win_valid),
  .win_ipi      (win_ipi),
  .win_prio     (win_prio),
  .take_rd      (stb.take_rd),
  .peek_rd      (stb.peek_rd),
  .eoi_wr       (stb.eoi_wr),
  .wdata        (bus_wdata_i),
  .irq_o        (irq_o),
  .src_accept_o (src_accept_o),
  .src_valid_i  (src_valid_i),
  .src_prio_i   (src_prio_i)
);

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_valid = 1'b0;
  logic [23:0] src_num = '0;
  logic [7:0]  src_prio = '0;
  logic        src_accept;
  logic        eoi_valid;
  logic [23:0] eoi_num;
  logic        irq;

  int total = 0;
  int fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        sample_ev;

  always #5 clk = ~clk;

  intr_presenter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_be_i     (bus_be),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .src_valid_i  (src_valid),
    .src_num_i    (src_num),
    .src_prio_i   (src_prio),
    .src_accept_o (src_accept),
    .eoi_valid_o  (eoi_valid),
    .eoi_num_o    (eoi_num),
    .irq_o        (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a read is sampled
  always @(sample_ev) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, bus_rdata, e);
  end

  task automatic finish_op();
    @(posedge clk);
    #1;
    bus_req = 1'b0;
    bus_we  = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input logic acc,
                    input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    #2;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ->sample_ev;
    #0;
    chk({tag, " accept"}, {31'b0, src_accept}, {31'b0, acc});
    finish_op();
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic eoi, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    #2;
    chk({tag, " eoi pulse"}, {31'b0, eoi_valid}, {31'b0, eoi});
    if (eoi) chk({tag, " eoi num"}, {8'b0, eoi_num}, {8'b0, d[23:0]});
    finish_op();
  endtask

  task automatic set_src(input logic v, input logic [23:0] n, input logic [7:0] p);
    @(negedge clk);
    src_valid = v; src_num = n; src_prio = p;
    #2;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    #100_000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk_irq(1'b0, "R1 reset");
    rd(4'h0, 32'h0000_0000, 1'b0, "R1 peek after reset");
    rd(4'hC, 32'hFF00_0000, 1'b0, "R1 ipi after reset");

    set_src(1'b1, 24'h000123, 8'd5);
    chk_irq(1'b0, "R10 cppr zero");

    wr(4'h4, 4'b1000, 32'hFF00_ABCD, 1'b0, "R7 byte cppr write");
    #1 chk_irq(1'b1, "R2 prio 5 under FF");
    rd(4'h0, 32'hFF00_0123, 1'b0, "R3 peek");
    rd(4'h0, 32'hFF00_0123, 1'b0, "R3 peek repeat");

    rd(4'h4, 32'hFF00_0123, 1'b1, "R4 take ext");
    #1 chk_irq(1'b0, "R2 prio 5 not under 5");
    set_src(1'b0, 24'h0, 8'd0);
    rd(4'h4, 32'h0500_0000, 1'b0, "R4 take nothing");
    rd(4'h0, 32'h0500_0000, 1'b0, "R4 cppr kept");

    wr(4'hC, 4'b1000, 32'h0300_0000, 1'b0, "R5 post ipi");
    #1 chk_irq(1'b1, "R5 ipi presented");
    rd(4'hC, 32'h0300_0000, 1'b0, "R5 ipi readback");
    rd(4'h0, 32'h0500_0002, 1'b0, "R5 ipi source 2");

    set_src(1'b1, 24'h000044, 8'd3);
    rd(4'h0, 32'h0500_0002, 1'b0, "R6 tie to ipi");
    rd(4'h4, 32'h0500_0002, 1'b0, "R6 take ipi");
    #1 chk_irq(1'b0, "R4 ext 3 not under 3");
    rd(4'hC, 32'hFF00_0000, 1'b0, "R4 ipi cleared by take");

    wr(4'h4, 4'b1111, 32'hFF00_0002, 1'b1, "R8 eoi");
    rd(4'h0, 32'hFF00_0044, 1'b0, "R8 threshold restored");

    wr(4'hC, 4'b1000, 32'h0100_0000, 1'b0, "R6 ipi 1");
    rd(4'h0, 32'hFF00_0002, 1'b0, "R6 lower ipi wins");
    set_src(1'b1, 24'h000077, 8'd0);
    rd(4'h0, 32'hFF00_0077, 1'b0, "R6 lower ext wins");

    wr(4'hC, 4'b1000, 32'hFF00_0000, 1'b0, "R5 withdraw");
    rd(4'hC, 32'hFF00_0000, 1'b0, "R5 withdrawn");

    wr(4'h0, 4'b1111, 32'h0000_0000, 1'b0, "R9 write peek");
    rd(4'h0, 32'hFF00_0077, 1'b0, "R9 peek write ignored");
    wr(4'h8, 4'b1111, 32'h1234_5678, 1'b0, "R9 write reserved");
    rd(4'h8, 32'h0000_0000, 1'b0, "R9 reserved reads 0");
    wr(4'h4, 4'b0100, 32'h0000_0000, 1'b0, "R9 partial write");
    rd(4'h0, 32'hFF00_0077, 1'b0, "R9 partial ignored");

    set_src(1'b0, 24'h0, 8'd0);
    chk_irq(1'b0, "R10 ipi FF never shown");
    wr(4'h4, 4'b1000, 32'h0000_0000, 1'b0, "R10 cppr to zero");
    set_src(1'b1, 24'h000055, 8'd0);
    chk_irq(1'b0, "R10 zero blocks prio 0");
    rd(4'h0, 32'h0000_0000, 1'b0, "R10 nothing presented");

    #20;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule